// File: doc/BRIEF.md
# Presettable Cascadable Down-Counter Divider

This block is one stage of a synchronous binary down counter used for frequency division. A 4-bit count register steps down by one on each count event and can be loaded from a parallel preset word. A count event comes from a rising edge on the count-clock line, or from a falling edge on the inhibit line. Holding inhibit high blocks the count-clock line, and releasing inhibit then acts as a negative-edge clock. Both lines are asynchronous to the system clock. Each one passes through its own two-flop synchronizer, and edges are found by comparing the synchronized value with its value one cycle earlier.

A decoded zero flag is high when the count is zero and the cascade-feedback input is high. For a single stage, tie cascade feedback high and connect the zero flag back to the load input. The counter then reloads N as soon as it reaches zero, so it gives one zero pulse for every N count events. For a multi-digit divider, each stage's cascade feedback is taken from the zero flag of the next more significant stage. The less significant stage then reports zero only when the whole chain is at zero. That flag drives the load input of every stage, with no extra gating.

Top module: `dn_div_stage`

## Requirements
- R1: A high `rst` at a rising system-clock edge sets `count` to 0 at that edge. Reset has priority over load and count events.
- R2: A rising edge on `tick_in` while `inhibit` is low decrements `count` by one. The new value appears at the third rising system-clock edge after the input changes. Holding `tick_in` high produces only one decrement.
- R3: While `inhibit` is high, rising edges on `tick_in` leave `count` unchanged.
- R4: A falling edge on `inhibit` decrements `count` by one, with the same latency as R2.
- R5: A rising edge on `tick_in` and a falling edge on `inhibit` in the same cycle produce a single decrement.
- R6: If `load_en` is high at a rising system-clock edge, `count` takes the value of `preset` at that edge. This load overrides a count event due at the same edge.
- R7: A count event at `count` = 0 without a load wraps `count` to 15, the all-ones value.
- R8: `zero` is high exactly when `count` is 0 and `cascade_fb` is high. It follows these signals combinationally.
- R9: In single-stage use (`cascade_fb` = 1, `zero` driving `load_en`, `preset` = N), exactly one `zero` pulse occurs for every N count events, for each N from 1 to 15.
- R10: In a two-stage chain, both stages' `load_en` come from the low stage's `zero`, and the low stage's `cascade_fb` comes from the high stage's `zero`. The high stage's `tick_in` is high whenever the low stage's count is 0. With presets L for the low stage and M for the high stage (L ≥ 1, M ≥ 1), the low stage gives one `zero` pulse every 16·(M−1)+L low-stage count events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Count clock, asynchronous; its rising edge is a count event |
| inhibit | input | 1 | Asynchronous; a high level blocks tick_in, a falling edge is a count event |
| preset | input | W | Value loaded into the counter |
| load_en | input | 1 | Load preset at the next system-clock edge |
| cascade_fb | input | 1 | Qualifies the zero flag; tie high for a single stage |
| count | output | W | Current counter value |
| zero | output | 1 | High when count is zero and cascade_fb is high |

## Verification
A change on `tick_in` or `inhibit` reaches `count` three system-clock edges later: two synchronizer flops, then the count register. A load or reset takes effect at the first edge, and `zero` follows `count` in the same cycle. The bench drives every input on the falling clock edge. It holds each count-clock or inhibit level for at least four cycles and samples four falling edges later, after the three-edge latency has passed. The load-override case places `load_en` on the falling edge just before the edge at which the pending decrement would land. Divider periods are measured by counting `zero` pulses on each rising edge and comparing the running total with the number of completed count events.

// File: rtl/dn_div_pkg.sv
package dn_div_pkg;

    localparam int CNT_W_DEF      = 4;
    localparam int SYNC_DEPTH_DEF = 2;

    // synchronized level of one asynchronous input, plus its value one cycle earlier
    typedef struct packed {
        logic now;
        logic prev;
    } samp_t;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_DEC  = 2'd1,
        ACT_LOAD = 2'd2
    } cnt_act_e;

    // load wins over a count event
    function automatic cnt_act_e pick_action(input logic load, input logic evt);
        if (load)
            return ACT_LOAD;
        else if (evt)
            return ACT_DEC;
        else
            return ACT_HOLD;
    endfunction

    function automatic logic is_rise(input samp_t s);
        return s.now & ~s.prev;
    endfunction

    function automatic logic is_fall(input samp_t s);
        return ~s.now & s.prev;
    endfunction

endpackage

// File: rtl/dn_div_edge_sync.sv
module dn_div_edge_sync #(
    parameter int DEPTH = dn_div_pkg::SYNC_DEPTH_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                din,
    output dn_div_pkg::samp_t   samp_o
);
    logic [DEPTH-1:0] chain_q;
    logic             prev_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain_q[i] <= 1'b0;
                else     chain_q[i] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain_q[i] <= 1'b0;
                else     chain_q[i] <= chain_q[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain_q[DEPTH-1];
    end

    assign samp_o.now  = chain_q[DEPTH-1];
    assign samp_o.prev = prev_q;

endmodule

// File: rtl/dn_div_evt.sv
module dn_div_evt
    import dn_div_pkg::*;
(
    input  samp_t tick_s,
    input  samp_t inh_s,
    output logic  evt
);
    logic tick_ok;
    logic inh_edge;

    always_comb begin
        // count-clock rise only counts while inhibit is low
        tick_ok  = is_rise(tick_s) & ~inh_s.now;
        inh_edge = is_fall(inh_s);
        // OR-merge: coincident edges give one step
        evt      = tick_ok | inh_edge;
    end

endmodule

// File: rtl/dn_div_core.sv
module dn_div_core
    import dn_div_pkg::*;
#(
    parameter int W = CNT_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] preset,
    input  logic         evt,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] STEP = W'(1);

    cnt_act_e     act;
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    always_comb begin
        act = pick_action(load, evt);
        unique case (act)
            ACT_LOAD: cnt_d = preset;
            ACT_DEC:  cnt_d = cnt_q - STEP;
            default:  cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign count = cnt_q;

endmodule

// File: rtl/dn_div_zero.sv
module dn_div_zero #(
    parameter int W = dn_div_pkg::CNT_W_DEF
) (
    input  logic [W-1:0] count,
    input  logic         cascade_fb,
    output logic         zero
);
    logic all_clear;

    always_comb begin
        all_clear = ~(|count);
        zero      = all_clear & cascade_fb;
    end

endmodule

// File: rtl/dn_div_stage.sv
module dn_div_stage
    import dn_div_pkg::*;
#(
    parameter int W          = CNT_W_DEF,
    parameter int SYNC_DEPTH = SYNC_DEPTH_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_in,
    input  logic         inhibit,
    input  logic [W-1:0] preset,
    input  logic         load_en,
    input  logic         cascade_fb,
    output logic [W-1:0] count,
    output logic         zero
);
    localparam int N_ASYNC = 2;
    localparam int IDX_TICK = 0;
    localparam int IDX_INH  = 1;

    logic [N_ASYNC-1:0] raw_in;
    samp_t              samp [N_ASYNC];
    logic               count_evt;

    assign raw_in[IDX_TICK] = tick_in;
    assign raw_in[IDX_INH]  = inhibit;

    for (genvar k = 0; k < N_ASYNC; k++) begin : g_sync
        dn_div_edge_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
            .clk    (clk),
            .rst    (rst),
            .din    (raw_in[k]),
            .samp_o (samp[k])
        );
    end

    dn_div_evt u_evt (
        .tick_s (samp[IDX_TICK]),
        .inh_s  (samp[IDX_INH]),
        .evt    (count_evt)
    );

    dn_div_core #(.W(W)) u_core (
        .clk    (clk),
        .rst    (rst),
        .load   (load_en),
        .preset (preset),
        .evt    (count_evt),
        .count  (count)
    );

    dn_div_zero #(.W(W)) u_zero (
        .count      (count),
        .cascade_fb (cascade_fb),
        .zero       (zero)
    );

endmodule

// File: rtl/dn_div_stage_chk.sv
module dn_div_stage_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         load_en,
    input logic [W-1:0] preset,
    input logic         cascade_fb,
    input logic [W-1:0] count,
    input logic         zero,
    input logic         count_evt
);
    localparam logic [W-1:0] ONE = W'(1);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (count == '0));

    // R6
    load_value_chk: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (count == $past(preset)));

    // R2
    dec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_en && count_evt) |=> (count == ($past(count) - ONE)));

    // R3
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !count_evt) |=> $stable(count));

    // R8
    zero_qual_chk: assert property (@(posedge clk) disable iff (rst)
        zero |-> (cascade_fb && (count == '0)));

endmodule

bind dn_div_stage dn_div_stage_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .load_en    (load_en),
    .preset     (preset),
    .cascade_fb (cascade_fb),
    .count      (count),
    .zero       (zero),
    .count_evt  (count_evt)
);

// File: tb/dn_div_stage_tb_top.sv
module dn_div_stage_tb_top;
    localparam int W = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic         rst      = 1'b1;
    logic         tick_in  = 1'b0;
    logic         inhibit  = 1'b0;
    logic         ld_force = 1'b0;
    logic         fb_on    = 1'b0;
    logic         cfb      = 1'b1;
    logic [W-1:0] preset   = '0;
    logic         load_en;
    logic [W-1:0] count_s;
    logic         zero_s;

    assign load_en = ld_force | (fb_on & zero_s);

    dn_div_stage #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .tick_in(tick_in), .inhibit(inhibit),
        .preset(preset), .load_en(load_en), .cascade_fb(cfb),
        .count(count_s), .zero(zero_s)
    );

    // two-stage chain
    logic         ch_tick = 1'b0;
    logic         ch_ld   = 1'b0;
    logic [W-1:0] ch_l    = '0;
    logic [W-1:0] ch_m    = '0;
    logic [W-1:0] lsd_count, msd_count;
    logic         lsd_zero, msd_zero, ch_load, msd_tick;

    assign ch_load  = ch_ld | lsd_zero;
    assign msd_tick = ~(|lsd_count);

    dn_div_stage #(.W(W)) lsd_i (
        .clk(clk), .rst(rst), .tick_in(ch_tick), .inhibit(1'b0),
        .preset(ch_l), .load_en(ch_load), .cascade_fb(msd_zero),
        .count(lsd_count), .zero(lsd_zero)
    );

    dn_div_stage #(.W(W)) msd_i (
        .clk(clk), .rst(rst), .tick_in(msd_tick), .inhibit(1'b0),
        .preset(ch_m), .load_en(ch_load), .cascade_fb(1'b1),
        .count(msd_count), .zero(msd_zero)
    );

    int zp = 0;
    int zc = 0;
    always @(posedge clk) begin
        if (zero_s)   zp <= zp + 1;
        if (lsd_zero) zc <= zc + 1;
    end

    int  checks = 0;
    int  errors = 0;
    logic done  = 1'b0;

    // step table: op[9:8] data[7:4] expected count[3:0]
    // op 0 load, 1 count-clock pulse, 2 inhibit fall, 3 count-clock pulse under inhibit
    localparam int NSTEP = 15;
    localparam logic [9:0] STEPS [NSTEP] = '{
        {2'd0, 4'd9,  4'd9 },
        {2'd1, 4'd0,  4'd8 },
        {2'd1, 4'd0,  4'd7 },
        {2'd2, 4'd0,  4'd6 },
        {2'd3, 4'd0,  4'd6 },
        {2'd2, 4'd0,  4'd5 },
        {2'd0, 4'd1,  4'd1 },
        {2'd1, 4'd0,  4'd0 },
        {2'd1, 4'd0,  4'd15},
        {2'd3, 4'd0,  4'd15},
        {2'd2, 4'd0,  4'd14},
        {2'd0, 4'd0,  4'd0 },
        {2'd2, 4'd0,  4'd15},
        {2'd0, 4'd15, 4'd15},
        {2'd1, 4'd0,  4'd14}
    };

    localparam int NPAIR = 4;
    localparam logic [7:0] PAIRS [NPAIR] = '{
        {4'd1, 4'd3}, {4'd2, 4'd1}, {4'd2, 4'd5}, {4'd3, 4'd2}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tick();
        tick_in = 1'b1; wait_n(4);
        tick_in = 1'b0; wait_n(4);
    endtask

    task automatic pulse_inh();
        inhibit = 1'b1; wait_n(4);
        inhibit = 1'b0; wait_n(4);
    endtask

    task automatic held_tick();
        inhibit = 1'b1; wait_n(4);
        tick_in = 1'b1; wait_n(4);
        tick_in = 1'b0; wait_n(4);
    endtask

    task automatic do_load(input logic [W-1:0] v);
        preset = v; ld_force = 1'b1; wait_n(1);
        ld_force = 1'b0; wait_n(1);
    endtask

    task automatic chain_tick();
        ch_tick = 1'b1; wait_n(5);
        ch_tick = 1'b0; wait_n(5);
    endtask

    function automatic string step_tag(input logic [1:0] op, input logic [3:0] exp);
        if (op == 2'd0) return "R6 load";
        if (op == 2'd3) return "R3 inhibited tick";
        if (exp == 4'd15) return "R7 wrap";
        if (op == 2'd1) return "R2 tick";
        return "R4 inhibit fall";
    endfunction

    initial begin
        wait_n(3);
        check("R1 reset count", count_s, 0);
        check("R8 reset zero", zero_s, 1);
        rst = 1'b0;
        wait_n(2);

        for (int i = 0; i < NSTEP; i++) begin
            logic [1:0] op;
            logic [3:0] dat, exp;
            {op, dat, exp} = STEPS[i];
            case (op)
                2'd0: do_load(dat);
                2'd1: pulse_tick();
                2'd2: pulse_inh();
                default: held_tick();
            endcase
            check($sformatf("%s step %0d", step_tag(op, exp), i), count_s, exp);
            check($sformatf("R8 zero step %0d", i), zero_s, (exp == 4'd0) ? 1 : 0);
        end

        // R8 cascade qualifier
        do_load(4'd0);
        cfb = 1'b0; wait_n(1);
        check("R8 zero gated by cascade_fb", zero_s, 0);
        cfb = 1'b1; wait_n(1);
        check("R8 zero with cascade_fb", zero_s, 1);

        // R5 coincident edges
        do_load(4'd5);
        inhibit = 1'b1; wait_n(4);
        tick_in = 1'b1; inhibit = 1'b0; wait_n(6);
        check("R5 coincident edges", count_s, 4);
        tick_in = 1'b0; wait_n(4);
        check("R5 after release", count_s, 4);

        // R2 level held high counts once
        do_load(4'd10);
        tick_in = 1'b1; wait_n(20);
        check("R2 held level single step", count_s, 9);
        tick_in = 1'b0; wait_n(4);

        // R6 load overrides a pending decrement
        do_load(4'd7);
        tick_in = 1'b1; wait_n(2);
        preset = 4'd3; ld_force = 1'b1; wait_n(1);
        ld_force = 1'b0;
        check("R6 load over event", count_s, 3);
        wait_n(5);
        tick_in = 1'b0; wait_n(4);
        check("R6 no late decrement", count_s, 3);

        // R1 mid-run reset
        do_load(4'd12);
        rst = 1'b1; wait_n(1);
        check("R1 mid-run reset", count_s, 0);
        rst = 1'b0; wait_n(2);

        // R9 single-stage divide-by-N
        cfb = 1'b1;
        for (int n = 1; n <= 15; n++) begin
            int base;
            fb_on = 1'b0;
            do_load(n[W-1:0]);
            base  = zp;
            fb_on = 1'b1;
            for (int k = 1; k <= 2 * n; k++) begin
                pulse_tick();
                check($sformatf("R9 N=%0d tick %0d pulses", n, k), zp - base, k / n);
            end
        end
        fb_on = 1'b0;

        // R10 two-stage chain
        for (int p = 0; p < NPAIR; p++) begin
            int base, per;
            {ch_m, ch_l} = PAIRS[p];
            per   = 16 * (int'(ch_m) - 1) + int'(ch_l);
            ch_ld = 1'b1; wait_n(6);
            ch_ld = 1'b0; wait_n(2);
            base  = zc;
            for (int k = 1; k <= 2 * per; k++) begin
                chain_tick();
                if (k == per - 1 || k == per || k == 2 * per)
                    check($sformatf("R10 M=%0d L=%0d tick %0d pulses", ch_m, ch_l, k),
                          zc - base, k / per);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule